// File: doc/BRIEF.md
# Addressable Serial Transceiver with Line-Driver Control

This block is a full-duplex asynchronous serial port for 8-bit characters. Each character goes out least-significant bit first between a low start bit and one high stop bit. A ninth bit can follow the data. That bit carries even or odd parity, or an address/data marker when the port runs in multiprocessor mode. A 16-bit divisor sets the oversampling tick. One bit lasts 16 ticks, and the receiver samples each bit in its middle.

Software reaches the block through an 8-bit register port with eight locations. The port exposes a transmit holding register and a receive data register, a status byte, and the control registers. In multiprocessor mode the receiver compares each address character with a programmable node address and filters the traffic under one of three policies. The transmitter waits for a clear-to-send input when asked to. It can drive an enable output for a half-duplex bus transceiver, which opens ahead of each frame and closes after the stop bit. When both directions are switched off, the divisor tick raises a periodic timer interrupt instead.

Top module: `mpuart`

## Requirements
- R1: After reset, txd is 1, de is 0 and the status byte (location 1) reads 0x0C, which means transmit-empty bit 3 and transmitter-idle bit 2 are set. Status bit 7 is receive-full, bit 6 is overrun, bit 5 is framing error, bit 4 is parity error, bit 1 is first-data-of-frame and bit 0 is received-address-marker.
- R2: Location 5 holds the low byte of the divisor and location 6 holds the high byte. The tick comes every divisor clocks, or every clock when the divisor is 0 or 1. One bit lasts 16 ticks. With control bit 0 set, a byte written to location 0 goes out as a low start bit, eight data bits LSB first, an optional ninth bit and one high stop bit.
- R3: Control (location 2) bit 2 enables parity and bit 3 selects odd parity (0 = even). The ninth bit equals the XOR of the data bits XOR the odd-select bit. On receive, a mismatch sets status bit 4.
- R4: With control bit 5 set and cts_n high, a queued character does not start. Clearing cts_n lets it start.
- R5: With control bit 6 set, de rises between one and two bit times before the start bit. It stays high while any frame bit is on the line and falls after the stop bit ends.
- R6: Control bit 4 forces txd low while it is set.
- R7: Transmit-empty (status bit 3) is 0 from the clock after a write to location 0 until the byte moves into the shifter. Transmitter-idle (bit 2) is 1 only when the holding register is empty and no frame is in progress. tx_irq equals control bit 0 AND transmit-empty.
- R8: With control bit 1 set, a received character is placed in location 0 and sets receive-full and rx_irq. Reading location 0 clears receive-full, all error flags and bit 1.
- R9: A low stop bit sets the framing-error flag. A character that arrives while receive-full is set raises overrun and keeps the earlier byte.
- R10: Location 3 bit 0 enables multiprocessor mode. In this mode the ninth transmitted bit is location 3 bit 3. A received ninth bit of 1 marks an address, which is compared with location 4 and reported in status bit 0.
- R11: Policy 0 (location 3 bits 2:1 = 00) delivers every address character and every data character.
- R12: Policy 1 delivers only matching address characters and correctly framed data characters that follow a match. Policies 2 and 3 deliver only correctly framed data characters that follow a match.
- R13: The first data character delivered after a matching address sets status bit 1. Later data characters leave it clear.
- R14: With control bits 0 and 1 both clear, every tick sets the timer flag, which drives tmr_irq. Reading location 7 returns the flag in bit 0 and clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe (drives read side effects) |
| addr | input | 3 | Register location |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear-to-send, active low |
| de | output | 1 | Line-driver enable |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |
| tmr_irq | output | 1 | Divisor timer interrupt |

## Verification
The bench builds the block at its default widths and sets the divisor to 2 at run time, so one bit lasts 32 clocks. A whole frame, a flow-control stall and the driver-enable lead then fit within a few hundred cycles, and the tick-level edges of every bit can still be seen. With the reset divisor of 0, the tick fires every clock, which puts the timer interrupt within reach right after reset. A per-clock monitor checks that de is high whenever the line is driven low by a frame.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
    localparam int DIV_W = 16;

    typedef enum logic [2:0] {
        TX_IDLE, TX_LEAD, TX_START, TX_DATA, TX_NINTH, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_NINTH, RX_STOP
    } rx_state_e;
endpackage

// File: rtl/mpuart_baud.sv
module mpuart_baud
    import mpuart_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_t;

    baud_t d, q;

    always_comb begin
        d    = q;
        tick = (q.cnt <= 1);
        if (tick) d.cnt = divisor;
        else      d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2
    no_double_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor >= 2) |=> !tick);
endmodule

// File: rtl/mpuart_tx.sv
module mpuart_tx
    import mpuart_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       tx_en,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       brk,
    input  logic       cts_en,
    input  logic       cts_n,
    input  logic       de_en,
    input  logic       mp_en,
    input  logic       mp_bit,
    input  logic       load,
    input  logic [7:0] wdata,
    output logic       txd,
    output logic       de,
    output logic       tdre,
    output logic       txe
);
    localparam int CW = $clog2(OVS) + 1;
    localparam logic [CW-1:0] BIT_END  = CW'(OVS - 1);
    localparam logic [CW-1:0] LEAD_END = CW'(OVS);

    typedef struct packed {
        tx_state_e     st;
        logic [CW-1:0] cnt;
        logic [2:0]    idx;
        logic [7:0]    shf;
        logic          ninth;
        logic          has9;
        logic [7:0]    thr;
        logic          full;
    } tx_t;

    tx_t  d, q;
    logic adv;
    logic line;

    always_comb begin
        d   = q;
        adv = 1'b0;
        if (q.st != TX_IDLE && tick) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == ((q.st == TX_LEAD) ? LEAD_END : BIT_END)) begin
                d.cnt = '0;
                adv   = 1'b1;
            end
        end
        case (q.st)
            TX_IDLE: if (tx_en && q.full && !(cts_en && cts_n)) begin
                d.shf   = q.thr;
                d.ninth = mp_en ? mp_bit : (^q.thr ^ par_odd);
                d.has9  = mp_en || par_en;
                d.full  = 1'b0;
                d.cnt   = '0;
                d.st    = de_en ? TX_LEAD : TX_START;
            end
            TX_LEAD:  if (adv) d.st = TX_START;
            TX_START: if (adv) begin d.st = TX_DATA; d.idx = '0; end
            TX_DATA:  if (adv) begin
                d.shf = q.shf >> 1;
                d.idx = q.idx + 1'b1;
                if (q.idx == 3'd7) d.st = q.has9 ? TX_NINTH : TX_STOP;
            end
            TX_NINTH: if (adv) d.st = TX_STOP;
            TX_STOP:  if (adv) d.st = TX_IDLE;
            default:  d.st = TX_IDLE;
        endcase
        if (load) begin
            d.thr  = wdata;
            d.full = 1'b1;
        end
    end

    always_comb begin
        case (q.st)
            TX_START: line = 1'b0;
            TX_DATA:  line = q.shf[0];
            TX_NINTH: line = q.ninth;
            default:  line = 1'b1;
        endcase
        txd  = brk ? 1'b0 : line;
        de   = de_en && (q.st != TX_IDLE);
        tdre = !q.full;
        txe  = !q.full && (q.st == TX_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_en && cts_n && q.st == TX_IDLE) |=> (q.st == TX_IDLE));
    // R5
    de_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (de_en && !brk && !txd) |-> de);
    // R7
    load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !tdre);
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       mp_en,
    output logic       done,
    output logic [7:0] data,
    output logic       ninth,
    output logic       fe,
    output logic       pe
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    typedef struct packed {
        logic [1:0]    sync;
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [2:0]    idx;
        logic [7:0]    shf;
        logic          ninth;
        logic          done;
        logic          fe;
        logic          pe;
    } rx_t;

    rx_t  d, q;
    logic bit_now;
    logic samp;

    always_comb begin
        d       = q;
        d.sync  = {q.sync[0], rxd};
        d.done  = 1'b0;
        bit_now = q.sync[1];
        samp    = tick && (q.cnt == ((q.st == RX_START) ? MID : LAST));
        if (tick && q.st != RX_IDLE) d.cnt = q.cnt + 1'b1;
        case (q.st)
            RX_IDLE: if (tick && !bit_now) begin
                d.st  = RX_START;
                d.cnt = '0;
            end
            RX_START: if (samp) begin
                d.cnt = '0;
                d.idx = '0;
                d.st  = bit_now ? RX_IDLE : RX_DATA;
            end
            RX_DATA: if (samp) begin
                d.shf = {bit_now, q.shf[7:1]};
                d.idx = q.idx + 1'b1;
                if (q.idx == 3'd7) d.st = (par_en || mp_en) ? RX_NINTH : RX_STOP;
            end
            RX_NINTH: if (samp) begin
                d.ninth = bit_now;
                d.st    = RX_STOP;
            end
            RX_STOP: if (samp) begin
                d.done = 1'b1;
                d.fe   = !bit_now;
                d.pe   = par_en && !mp_en && (q.ninth != (^q.shf ^ par_odd));
                d.st   = RX_IDLE;
            end
            default: d.st = RX_IDLE;
        endcase
        if (!rx_en) d.st = RX_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign done  = q.done;
    assign data  = q.shf;
    assign ninth = q.ninth;
    assign fe    = q.fe;
    assign pe    = q.pe;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/mpuart.sv
module mpuart
    import mpuart_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       rd,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rxd,
    output logic       txd,
    input  logic       cts_n,
    output logic       de,
    output logic       rx_irq,
    output logic       tx_irq,
    output logic       tmr_irq
);
    typedef struct packed {
        logic [6:0]       ctrl;
        logic [3:0]       mpc;
        logic [7:0]       node;
        logic [DIV_W-1:0] div;
        logic [7:0]       rdr;
        logic             rdrf;
        logic             oe;
        logic             fe;
        logic             pe;
        logic             newfrm;
        logic             mprx;
        logic             matched;
        logic             first;
        logic             tmr;
    } regs_t;

    regs_t d, q;
    logic tick, tdre, txe;
    logic rx_done, rx_ninth, rx_fe, rx_pe;
    logic [7:0] rx_data;
    logic is_addr, hit, deliver;

    wire tx_en   = q.ctrl[0];
    wire rx_en   = q.ctrl[1];
    wire par_en  = q.ctrl[2];
    wire par_odd = q.ctrl[3];
    wire brk     = q.ctrl[4];
    wire cts_en  = q.ctrl[5];
    wire de_en   = q.ctrl[6];
    wire mp_en   = q.mpc[0];
    wire [1:0] mode = q.mpc[2:1];
    wire mp_bit  = q.mpc[3];

    mpuart_baud u_baud (.clk(clk), .rst_n(rst_n), .divisor(q.div), .tick(tick));

    mpuart_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .par_en(par_en),
        .par_odd(par_odd), .brk(brk), .cts_en(cts_en), .cts_n(cts_n), .de_en(de_en),
        .mp_en(mp_en), .mp_bit(mp_bit), .load(wr && addr == 3'd0), .wdata(wdata),
        .txd(txd), .de(de), .tdre(tdre), .txe(txe));

    mpuart_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_en(rx_en),
        .par_en(par_en), .par_odd(par_odd), .mp_en(mp_en), .done(rx_done),
        .data(rx_data), .ninth(rx_ninth), .fe(rx_fe), .pe(rx_pe));

    always_comb begin
        d       = q;
        is_addr = mp_en && rx_ninth;
        hit     = (rx_data == q.node);
        deliver = 1'b0;
        if (wr) begin
            case (addr)
                3'd2:    d.ctrl      = wdata[6:0];
                3'd3:    d.mpc       = wdata[3:0];
                3'd4:    d.node      = wdata;
                3'd5:    d.div[7:0]  = wdata;
                3'd6:    d.div[15:8] = wdata;
                default: ;
            endcase
        end
        if (rd && addr == 3'd0) begin
            d.rdrf   = 1'b0;
            d.oe     = 1'b0;
            d.fe     = 1'b0;
            d.pe     = 1'b0;
            d.newfrm = 1'b0;
            d.mprx   = 1'b0;
        end
        if (rd && addr == 3'd7) d.tmr = 1'b0;
        if (tick && !tx_en && !rx_en) d.tmr = 1'b1;
        if (rx_done) begin
            if (!mp_en) begin
                deliver = 1'b1;
            end else if (is_addr) begin
                d.matched = hit;
                d.first   = hit;
                deliver   = (mode == 2'd0) || (mode == 2'd1 && hit);
            end else begin
                deliver = (mode == 2'd0) || (q.matched && !rx_fe);
            end
            if (deliver) begin
                if (d.rdrf) begin
                    d.oe = 1'b1;
                end else begin
                    d.rdr    = rx_data;
                    d.rdrf   = 1'b1;
                    d.fe     = rx_fe;
                    d.pe     = rx_pe;
                    d.mprx   = is_addr;
                    d.newfrm = !is_addr && mp_en && q.first;
                end
                if (!is_addr) d.first = 1'b0;
            end
        end
    end

    always_comb begin
        case (addr)
            3'd0:    rdata = q.rdr;
            3'd1:    rdata = {q.rdrf, q.oe, q.fe, q.pe, tdre, txe, q.newfrm, q.mprx};
            3'd2:    rdata = {1'b0, q.ctrl};
            3'd3:    rdata = {4'b0, q.mpc};
            3'd4:    rdata = q.node;
            3'd5:    rdata = q.div[7:0];
            3'd6:    rdata = q.div[15:8];
            default: rdata = {7'b0, q.tmr};
        endcase
    end

    assign rx_irq  = rx_en && (q.rdrf || q.oe);
    assign tx_irq  = tx_en && tdre;
    assign tmr_irq = q.tmr;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> $past(q.rdrf));
    // R14
    tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !tx_en && !rx_en) |=> tmr_irq);
    // R13
    newfrm_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.newfrm |-> q.rdrf);
endmodule

// File: tb/mpuart_test.sv
module mpuart_test;
    logic       clk = 1'b0;
    logic       rst_n, wr, rd, rxd, cts_n;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       txd, de, rx_irq, tx_irq, tmr_irq;

    int tests = 0;
    int fails = 0;
    int mon_fail = 0;
    int cyc = 0;
    bit de_mode = 1'b0;
    bit brk_mode = 1'b0;

    always #5 clk = ~clk;

    mpuart uut (
        .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rxd(rxd), .txd(txd), .cts_n(cts_n), .de(de),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .tmr_irq(tmr_irq));

    // per-clock monitor of the line driver against the bench's own mode flags
    always @(negedge clk) begin
        if (rst_n === 1'b1 && de_mode && !brk_mode && txd === 1'b0 && de !== 1'b1) begin
            mon_fail++;
            $display("FAIL R5: de actual %b expected 1 while line low", de);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails + mon_fail + 1);
            $finish;
        end
    end

    task automatic tick_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    function automatic logic par_of(input logic [7:0] v, input logic odd);
        logic p = odd;
        for (int i = 0; i < 8; i++) p ^= v[i];
        return p;
    endfunction

    // one bit = 16 ticks x divisor 2 = 32 clocks
    task automatic send_rx(input logic [7:0] v, input bit nine_on, input logic nine, input bit stop_ok);
        rxd = 1'b0; tick_n(32);
        for (int i = 0; i < 8; i++) begin rxd = v[i]; tick_n(32); end
        if (nine_on) begin rxd = nine; tick_n(32); end
        if (stop_ok) begin rxd = 1'b1; tick_n(32); end
        else begin rxd = 1'b0; tick_n(20); rxd = 1'b1; end
        tick_n(60);
    endtask

    task automatic cap_tx(input bit nine_on, output logic [7:0] v, output logic nine, output bit ok);
        int t = 0;
        logic s0, s1;
        nine = 1'b0;
        while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
        tick_n(16); s0 = txd;
        for (int i = 0; i < 8; i++) begin tick_n(32); v[i] = txd; end
        if (nine_on) begin tick_n(32); nine = txd; end
        tick_n(32); s1 = txd;
        ok = (t < 5000) && s0 == 1'b0 && s1 == 1'b1;
    endtask

    initial begin
        logic [7:0] v, st;
        logic       n;
        bit         okf;
        int         t;
        rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; rxd = 1'b1; cts_n = 1'b0;
        tick_n(4);
        rst_n = 1'b1;
        tick_n(1);
        chk("R1 txd", txd, 1);
        chk("R1 de", de, 0);
        rd_reg(3'd1, st);
        chk("R1 status", st, 8'h0C);

        // R14: divisor 0 after reset ticks every clock
        tick_n(3);
        chk("R14 tmr_irq", tmr_irq, 1);
        rd_reg(3'd7, v);
        chk("R14 flag read", v, 8'h01);
        wr_reg(3'd5, 8'd2);
        wr_reg(3'd6, 8'd0);
        wr_reg(3'd2, 8'h03);
        rd_reg(3'd7, v);
        tick_n(10);
        rd_reg(3'd7, v);
        chk("R14 stopped when enabled", v, 8'h00);
        chk("R14 tmr_irq low", tmr_irq, 0);
        chk("R7 tx_irq", tx_irq, 1);

        // R2 / R7 plain transmit
        wr_reg(3'd0, 8'hA5);
        rd_reg(3'd1, st);
        chk("R7 tdre after write", st[3], 0);
        chk("R7 txe busy", st[2], 0);
        cap_tx(1'b0, v, n, okf);
        chk("R2 framing", okf, 1);
        chk("R2 data A5", v, 8'hA5);
        tick_n(40);
        rd_reg(3'd1, st);
        chk("R7 idle again", st[3:2], 2'b11);
        wr_reg(3'd0, 8'h81);
        cap_tx(1'b0, v, n, okf);
        chk("R2 data 81", v, 8'h81);
        tick_n(40);

        // R3 odd parity transmit
        wr_reg(3'd2, 8'h0F);
        wr_reg(3'd0, 8'h03);
        cap_tx(1'b1, v, n, okf);
        chk("R3 tx data", v, 8'h03);
        chk("R3 tx odd parity bit", n, par_of(8'h03, 1'b1));
        tick_n(40);

        // R3 even parity receive, wrong then right
        wr_reg(3'd2, 8'h07);
        send_rx(8'h3C, 1'b1, ~par_of(8'h3C, 1'b0), 1'b1);
        rd_reg(3'd1, st);
        chk("R3 pe set", st[4], 1);
        rd_reg(3'd0, v);
        chk("R3 data", v, 8'h3C);
        send_rx(8'h3D, 1'b1, par_of(8'h3D, 1'b0), 1'b1);
        rd_reg(3'd1, st);
        chk("R3 pe clear on good parity", {st[7], st[4]}, 2'b10);
        rd_reg(3'd0, v);

        // R8 plain receive
        wr_reg(3'd2, 8'h03);
        send_rx(8'hC3, 1'b0, 1'b0, 1'b1);
        chk("R8 rx_irq", rx_irq, 1);
        rd_reg(3'd1, st);
        chk("R8 full", st[7], 1);
        rd_reg(3'd0, v);
        chk("R8 data C3", v, 8'hC3);
        chk("R8 rx_irq cleared", rx_irq, 0);
        rd_reg(3'd1, st);
        chk("R8 full cleared", st[7], 0);

        // R9 framing error and overrun
        send_rx(8'h5A, 1'b0, 1'b0, 1'b0);
        rd_reg(3'd1, st);
        chk("R9 fe", st[5], 1);
        rd_reg(3'd0, v);
        send_rx(8'h11, 1'b0, 1'b0, 1'b1);
        send_rx(8'h22, 1'b0, 1'b0, 1'b1);
        rd_reg(3'd1, st);
        chk("R9 overrun", st[6], 1);
        rd_reg(3'd0, v);
        chk("R9 older byte kept", v, 8'h11);

        // R6 break
        brk_mode = 1'b1;
        wr_reg(3'd2, 8'h13);
        chk("R6 txd forced low", txd, 0);
        wr_reg(3'd2, 8'h03);
        chk("R6 txd released", txd, 1);
        brk_mode = 1'b0;

        // R4 clear-to-send
        wr_reg(3'd2, 8'h23);
        cts_n = 1'b1;
        wr_reg(3'd0, 8'h5A);
        tick_n(200);
        chk("R4 held line", txd, 1);
        rd_reg(3'd1, st);
        chk("R4 still queued", st[3:2], 2'b00);
        cts_n = 1'b0;
        cap_tx(1'b0, v, n, okf);
        chk("R4 sent after release", v, 8'h5A);
        tick_n(40);

        // R5 driver enable
        wr_reg(3'd2, 8'h43);
        de_mode = 1'b1;
        wr_reg(3'd0, 8'hC6);
        t = 0;
        while (de !== 1'b1 && t < 100) begin @(negedge clk); t++; end
        t = 0;
        while (txd !== 1'b0 && t < 200) begin @(negedge clk); t++; end
        tests++;
        if (t < 32 || t > 64) begin
            fails++;
            $display("FAIL R5 lead: actual %0d expected 32..64", t);
        end
        cap_tx(1'b0, v, n, okf);
        chk("R5 data", v, 8'hC6);
        chk("R5 de during stop", de, 1);
        tick_n(20);
        chk("R5 de released", de, 0);
        de_mode = 1'b0;
        wr_reg(3'd2, 8'h03);

        // R10 multiprocessor transmit and policy 0
        wr_reg(3'd4, 8'h42);
        wr_reg(3'd3, 8'h09);
        wr_reg(3'd0, 8'h81);
        cap_tx(1'b1, v, n, okf);
        chk("R10 address marker sent", n, 1);
        tick_n(40);
        wr_reg(3'd3, 8'h01);
        send_rx(8'h10, 1'b1, 1'b1, 1'b1);
        rd_reg(3'd1, st);
        chk("R11 address delivered", {st[7], st[0]}, 2'b11);
        rd_reg(3'd0, v);
        chk("R10 address byte", v, 8'h10);
        send_rx(8'h33, 1'b1, 1'b0, 1'b1);
        rd_reg(3'd1, st);
        chk("R11 data delivered", {st[7], st[0]}, 2'b10);
        rd_reg(3'd0, v);

        // R12 / R13 policy 1
        wr_reg(3'd3, 8'h03);
        send_rx(8'h10, 1'b1, 1'b1, 1'b1);
        rd_reg(3'd1, st);
        chk("R12 mismatch address dropped", st[7], 0);
        send_rx(8'h55, 1'b1, 1'b0, 1'b1);
        rd_reg(3'd1, st);
        chk("R12 data for other node dropped", st[7], 0);
        send_rx(8'h42, 1'b1, 1'b1, 1'b1);
        rd_reg(3'd1, st);
        chk("R12 matching address", {st[7], st[0]}, 2'b11);
        rd_reg(3'd0, v);
        send_rx(8'h66, 1'b1, 1'b0, 1'b1);
        rd_reg(3'd1, st);
        chk("R13 first data flagged", {st[7], st[1], st[0]}, 3'b110);
        rd_reg(3'd0, v);
        chk("R12 data 66", v, 8'h66);
        rd_reg(3'd1, st);
        chk("R13 cleared by read", st[1], 0);
        send_rx(8'h67, 1'b1, 1'b0, 1'b1);
        rd_reg(3'd1, st);
        chk("R13 later data unflagged", {st[7], st[1]}, 2'b10);
        rd_reg(3'd0, v);

        // R12 policy 2
        wr_reg(3'd3, 8'h05);
        send_rx(8'h42, 1'b1, 1'b1, 1'b1);
        rd_reg(3'd1, st);
        chk("R12 data-only drops address", st[7], 0);
        send_rx(8'h77, 1'b1, 1'b0, 1'b1);
        rd_reg(3'd1, st);
        chk("R13 first data after match", {st[7], st[1]}, 2'b11);
        rd_reg(3'd0, v);
        chk("R12 data 77", v, 8'h77);
        send_rx(8'h78, 1'b1, 1'b0, 1'b0);
        rd_reg(3'd1, st);
        chk("R12 badly framed data dropped", st[7], 0);
        send_rx(8'h10, 1'b1, 1'b1, 1'b1);
        send_rx(8'h79, 1'b1, 1'b0, 1'b1);
        rd_reg(3'd1, st);
        chk("R12 data after mismatch dropped", st[7], 0);

        tests++;
        $display("[TB] %0d tests run, %0d failed", tests, fails + mon_fail);
        $finish;
    end
endmodule